// File: doc/BRIEF.md
# Indirect Byte-Wide Register Port

This block lets a host with an 8-bit data bus and a 3-bit address reach a much wider internal register space. The host only ever sees eight locations. Two of them set a pointer into the internal space: a low-address byte and a mode byte. The low two bits of the mode byte extend the pointer, and its top two bits choose the auto-increment rule. The remaining locations are staging bytes for one internal word of up to 40 bits.

Words move between the staging bytes and the internal registers only through staging location 0. Reading location 0 fetches the whole addressed word into the staging bytes, and the upper bytes can then be read without touching the internal space again. Writing location 0 commits that byte together with the upper staging bytes that were written earlier. The internal registers are modelled as a plain memory inside the block.

The host can use either of two pin conventions, chosen by a mode input. One uses separate read and write strobes. The other uses a data strobe with a read/write select. In both conventions an active-low acknowledge tells the host when the access may end. Accesses that move a whole word hold the acknowledge off for a fixed number of extra clocks.

Top module: `hostreg_port`

## Requirements
- R1: After reset, the low-address byte, the mode byte and all staging bytes read 0, and `ack_n` is high while no strobe is active.
- R2: Location 6 holds the low-address byte and location 7 holds the mode byte; both read back what was written. Location 5 (unused with 40-bit words) reads 0, and writes to it change nothing.
- R3: The internal word address is {mode byte bits 1:0, low-address byte}. Words at different addresses are independent.
- R4: Writing locations 1 to 4 only updates staging bytes for bits 15:8, 23:16, 31:24 and 39:32, and the internal word is unchanged. Writing location 0 stores {staged bytes 4..1, written byte} into the addressed word.
- R5: Reading location 0 returns bits 7:0 of the addressed word and copies the whole word into the staging bytes. Locations 1 to 4 then return bits 15:8 to 39:32 of that word.
- R6: Mode byte bits 7:6 select auto-increment: 00 never, 01 after a location-0 read, 10 after a location-0 write, 11 after either.
- R7: Only location-0 accesses change the address. The increment carries from the low-address byte into mode bits 1:0 and wraps from 0x3FF to 0x000. Mode bits 7:2 are never changed by an increment.
- R8: With `mode_sel`=0, `rd_ds_n` low is a read strobe and `wr_rw` low is a write strobe, both qualified by `cs_n` low.
- R9: With `mode_sel`=1, `rd_ds_n` low is a data strobe qualified by `cs_n` low, and `wr_rw` selects read (1) or write (0).
- R10: For a register access, `ack_n` goes low one clock after the strobe starts. For a location-0 access it goes low after 1+BUSY_CYC clocks (3 by default). It returns high one clock after the strobe ends.
- R11: A strobe held active for many clocks performs exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Pin convention: 0 separate strobes, 1 data strobe plus read/write select |
| cs_n | input | 1 | Active-low chip select |
| rd_ds_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| wr_rw | input | 1 | Write strobe, active low (mode 0) or read/write select, 1 = read (mode 1) |
| addr | input | 3 | External location |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host for the addressed location |
| ack_n | output | 1 | Active-low ready / data acknowledge |

## Verification
A location-0 access does two things on one clock edge: it moves a word (a fetch or a commit) and, in the matching increment mode, it bumps the address. The word must use the pointer value from before the edge. The bench provokes this by committing and fetching under mode 11 and under the 01/10 combinations. It then reads the pointer back through locations 6 and 7, and re-fetches the word at the old address with the increment turned off. This confirms that the data landed before the pointer moved, and that the carry into the mode byte left bits 7:2 intact.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam logic [2:0] LOC_WORD0 = 3'd0;
  localparam logic [2:0] LOC_LOW   = 3'd6;
  localparam logic [2:0] LOC_MODE  = 3'd7;

  // Increment the pointer field ({mode[upw-1:0], low}) inside the 16-bit
  // {mode, low} pair, keeping every bit above the field untouched.
  function automatic logic [15:0] bump_addr(input logic [15:0] pair, input int unsigned upw);
    logic [15:0] field_mask;
    field_mask = 16'((32'd1 << (8 + upw)) - 1);
    return (pair & ~field_mask) | ((pair + 16'd1) & field_mask);
  endfunction

  // Decide from mode bits 7:6 whether a word access moves the pointer.
  function automatic logic inc_wanted(input logic [1:0] rule, input logic is_rd, input logic is_wr);
    return (rule[0] & is_rd) | (rule[1] & is_wr);
  endfunction
endpackage

// File: rtl/hrp_strobe.sv
module hrp_strobe #(
  parameter int BUSY_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic cs_n,
  input  logic rd_ds_n,
  input  logic wr_rw,
  input  logic is_word,
  output logic start_rd,
  output logic start_wr,
  output logic held,
  output logic ack_n
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic          active;
  logic          is_wr;
  logic          start;
  logic [CW-1:0] busy_q;

  always_comb begin
    if (mode_sel) active = !cs_n && !rd_ds_n;
    else          active = !cs_n && (!rd_ds_n || !wr_rw);
    is_wr = !wr_rw;
  end

  assign start    = active && !held;
  assign start_rd = start && !is_wr;
  assign start_wr = start && is_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 1'b0;
      busy_q <= '0;
    end else begin
      held <= active;
      if (start && is_word)  busy_q <= CW'(BUSY_CYC);
      else if (busy_q != '0) busy_q <= busy_q - 1'b1;
    end
  end

  assign ack_n = !(held && busy_q == '0);
endmodule

// File: rtl/hrp_addr.sv
module hrp_addr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_low,
  input  logic              wr_mode,
  input  logic              bump,
  input  logic [7:0]        din,
  output logic [7:0]        low_q,
  output logic [7:0]        mode_q,
  output logic [ADDR_W-1:0] iaddr
);
  import hrp_pkg::*;
  localparam int UPW = ADDR_W - 8;

  logic [15:0] next_pair;
  assign next_pair = bump_addr({mode_q, low_q}, UPW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q  <= '0;
      mode_q <= '0;
    end else if (wr_low) begin
      low_q <= din;
    end else if (wr_mode) begin
      mode_q <= din;
    end else if (bump) begin
      {mode_q, low_q} <= next_pair;
    end
  end

  assign iaddr = {mode_q[UPW-1:0], low_q};
endmodule

// File: rtl/hrp_stage.sv
module hrp_stage #(
  parameter int WORD_W = 40,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] iaddr,
  input  logic              fetch,
  input  logic [WORD_W/8-1:0] byte_we,
  input  logic [7:0]        din,
  output logic [WORD_W-1:0] stage_q
);
  localparam int NB    = WORD_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [0:DEPTH-1];
  logic [WORD_W-1:0] rd_word;

  assign rd_word = mem[iaddr];

  always_ff @(posedge clk) begin
    if (byte_we[0]) mem[iaddr] <= {stage_q[WORD_W-1:8], din};
  end

  for (genvar k = 0; k < NB; k++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)          stage_q[k*8 +: 8] <= '0;
      else if (fetch)      stage_q[k*8 +: 8] <= rd_word[k*8 +: 8];
      else if (byte_we[k]) stage_q[k*8 +: 8] <= din;
    end
  end
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port #(
  parameter int WORD_W   = 40,
  parameter int ADDR_W   = 10,
  parameter int BUSY_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sel,
  input  logic       cs_n,
  input  logic       rd_ds_n,
  input  logic       wr_rw,
  input  logic [2:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       ack_n
);
  import hrp_pkg::*;
  localparam int NB = WORD_W / 8;

  logic              start_rd, start_wr, held;
  logic              is_word;
  logic              fetch, bump;
  logic [NB-1:0]     byte_we;
  logic [7:0]        low_q, mode_q;
  logic [ADDR_W-1:0] iaddr;
  logic [WORD_W-1:0] stage_q;

  assign is_word = (addr == LOC_WORD0);
  assign fetch   = start_rd && is_word;
  assign bump    = is_word && inc_wanted(mode_q[7:6], start_rd, start_wr);

  for (genvar k = 0; k < NB; k++) begin : g_we
    assign byte_we[k] = start_wr && (addr == 3'(k));
  end

  hrp_strobe #(.BUSY_CYC(BUSY_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
    .rd_ds_n(rd_ds_n), .wr_rw(wr_rw), .is_word(is_word),
    .start_rd(start_rd), .start_wr(start_wr), .held(held), .ack_n(ack_n)
  );

  hrp_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .wr_low(start_wr && addr == LOC_LOW),
    .wr_mode(start_wr && addr == LOC_MODE),
    .bump(bump), .din(din),
    .low_q(low_q), .mode_q(mode_q), .iaddr(iaddr)
  );

  hrp_stage #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .iaddr(iaddr), .fetch(fetch),
    .byte_we(byte_we), .din(din), .stage_q(stage_q)
  );

  always_comb begin
    dout = '0;
    if (addr == LOC_MODE)      dout = mode_q;
    else if (addr == LOC_LOW)  dout = low_q;
    else if (int'(addr) < NB)  dout = stage_q[int'(addr)*8 +: 8];
  end
endmodule

// File: rtl/hrp_checker.sv
module hrp_checker #(
  parameter int ADDR_W = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_rd,
  input logic       start_wr,
  input logic [2:0] addr,
  input logic [7:0] low_q,
  input logic [7:0] mode_q,
  input logic       ack_n
);
  localparam int UPW = ADDR_W - 8;
  logic [ADDR_W-1:0] ptr;
  logic              any_start;
  assign ptr       = {mode_q[UPW-1:0], low_q};
  assign any_start = start_rd || start_wr;

  assert_word_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_start && addr == 3'd0) |=> ack_n);

  assert_inc_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd && addr == 3'd0 && mode_q[6]) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

  assert_hold_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd && addr == 3'd0 && !mode_q[6]) |=> $stable({mode_q, low_q}));

  assert_hold_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && addr == 3'd0 && !mode_q[7]) |=> $stable({mode_q, low_q}));

  assert_no_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_start && addr != 3'd0 && !(start_wr && addr >= 3'd6)) |=> $stable({mode_q, low_q}));

  assert_rule_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_start && addr == 3'd0) |=> $stable(mode_q[7:UPW]));
endmodule

bind hostreg_port hrp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
  .addr(addr), .low_q(low_q), .mode_q(mode_q), .ack_n(ack_n)
);

// File: tb/tb_hostreg_port.sv
module tb_hostreg_port;
  localparam int BUSY = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0, cs_n = 1'b1, rd_ds_n = 1'b1, wr_rw = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       ack_n;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  hostreg_port #(.WORD_W(40), .ADDR_W(10), .BUSY_CYC(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
    .rd_ds_n(rd_ds_n), .wr_rw(wr_rw), .addr(addr), .din(din),
    .dout(dout), .ack_n(ack_n)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // One host access; checks the acknowledge delay and release (R10).
  task automatic access(input bit wr, input logic [2:0] a, input logic [7:0] d, output logic [7:0] q);
    int n = 0;
    @(negedge clk);
    addr = a; din = d; cs_n = 1'b0;
    if (mode_sel) begin rd_ds_n = 1'b0; wr_rw = !wr; end
    else if (wr)  wr_rw = 1'b0;
    else          rd_ds_n = 1'b0;
    do begin @(negedge clk); n++; end while (ack_n && n < 20);
    q = dout;
    check("R10 ack delay", n, (a == 3'd0) ? 1 + BUSY : 1);
    cs_n = 1'b1; rd_ds_n = 1'b1; wr_rw = 1'b1;
    @(negedge clk);
    check("R10 ack release", ack_n, 1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q;
    access(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] q;
    access(1'b0, a, 8'h00, q);
    check(tag, q, exp);
  endtask

  // {read, location, value}: read entries compare against value (mode 0 pins, R8)
  localparam int NV = 22;
  localparam logic [11:0] VEC [0:NV-1] = '{
    12'h703, 12'h603, 12'hF03, 12'hE03,          // R2 R3 pointer 0x303
    12'h4A5, 12'h344, 12'h233, 12'h122, 12'h011, // R4 stage then commit
    12'hE03,                                     // R6 rule 00 keeps pointer
    12'h100, 12'h200, 12'h300, 12'h400, 12'h900, // R4 staging only
    12'h811, 12'h922, 12'hA33, 12'hB44, 12'hCA5, // R5 fetch and upper bytes
    12'h55A, 12'hD00                             // R2 location 5 ignored
  };

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL R10 watchdog got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ack idle", ack_n, 1);
    rd(3'd6, 8'h00, "R1 low byte");
    rd(3'd7, 8'h00, "R1 mode byte");
    rd(3'd1, 8'h00, "R1 stage byte");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][11]) rd(VEC[i][10:8], VEC[i][7:0], $sformatf("R2/R4/R5 vector %0d", i));
      else            wr(VEC[i][10:8], VEC[i][7:0]);
    end

    // R3: address 0x103 is distinct from 0x303
    wr(3'd7, 8'h01); wr(3'd4, 8'h01); wr(3'd0, 8'h77);
    wr(3'd7, 8'h03); rd(3'd0, 8'h11, "R3 word 0x303 intact");
    wr(3'd7, 8'h01); rd(3'd0, 8'h77, "R3 word 0x103");
    rd(3'd4, 8'h01, "R3 word 0x103 top");

    // R6 rule 01: read bumps, write does not
    wr(3'd7, 8'h41); wr(3'd6, 8'hFE);
    wr(3'd0, 8'h10); rd(3'd6, 8'hFE, "R6 01 write no bump");
    rd(3'd0, 8'h10, "R6 01 fetch"); rd(3'd6, 8'hFF, "R6 01 read bump");
    // R6 rule 10 with carry into the mode byte (R7)
    wr(3'd7, 8'h81);
    rd(3'd0, 8'h00, "R6 10 fetch"); rd(3'd6, 8'hFF, "R6 10 read no bump");
    wr(3'd0, 8'h20); rd(3'd6, 8'h00, "R7 carry low");
    rd(3'd7, 8'h82, "R7 carry into mode");
    // R7 wrap at top and rule 11 (commit and bump on one edge)
    wr(3'd7, 8'hC3); wr(3'd6, 8'hFF);
    wr(3'd3, 8'h00); wr(3'd0, 8'h99);
    rd(3'd6, 8'h00, "R7 wrap low"); rd(3'd7, 8'hC0, "R7 wrap keeps rule");
    rd(3'd1, 8'h00, "R7 byte reg no bump"); rd(3'd6, 8'h00, "R7 byte reg no bump ptr");
    rd(3'd0, 8'h00, "R6 11 read"); rd(3'd6, 8'h01, "R6 11 read bump");
    wr(3'd7, 8'h03); wr(3'd6, 8'hFF);
    rd(3'd0, 8'h99, "R6 11 commit used old pointer");
    rd(3'd6, 8'hFF, "R6 00 no bump");

    // R9: data strobe with read/write select
    mode_sel = 1'b1;
    wr(3'd7, 8'h00); wr(3'd6, 8'h20);
    wr(3'd2, 8'h6B); wr(3'd0, 8'h5C);
    wr(3'd2, 8'h00);
    rd(3'd0, 8'h5C, "R9 fetch"); rd(3'd2, 8'h6B, "R9 upper byte");

    // R11: held strobe performs a single access
    wr(3'd7, 8'h40); wr(3'd6, 8'h30);
    @(negedge clk);
    addr = 3'd0; cs_n = 1'b0; rd_ds_n = 1'b0; wr_rw = 1'b1;
    repeat (10) @(negedge clk);
    cs_n = 1'b1; rd_ds_n = 1'b1;
    @(negedge clk);
    rd(3'd6, 8'h31, "R11 one bump per strobe");

    // R8: mode 0 write strobe with cs_n high does nothing
    mode_sel = 1'b0;
    @(negedge clk);
    addr = 3'd6; din = 8'hAA; wr_rw = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 no ack without select", ack_n, 1);
    wr_rw = 1'b1;
    rd(3'd6, 8'h31, "R8 unselected write ignored");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule